// File: doc/BRIEF.md
# DMA External Request Qualifier

This unit sits between one channel's active-low device request pin and that channel's transfer sequencer. It turns the pin into a "request pending" flag that the sequencer acts on. It also gives a "retain bus" decision that the sequencer samples when it finishes an operand. The pin may be driven from a clock domain unrelated to the controller, so it is first passed through a synchroniser. Every later decision is made on the synchronised copy.

The mode input selects one of three ways of reading the pin:
- **Burst:** the pin is read as a level.
- **Cycle steal:** each falling edge requests exactly one operand. The bus is released after each operand, unless the device has already made a new request while the current operand was still being moved.
- **Cycle steal with hold:** the same edge rule, but the bus stays owned between operands.

A separate mixed-start option makes the first operand after channel activation self-requested. Later operands then wait for the device.

The sequencer tells the unit three things:
- whether the channel is active (`chan_act`);
- whether the controller currently owns the bus (`bus_owned`);
- when the strobe of an operand's final part is asserted (`last_dtc`).

An operand is considered complete in the cycle where `last_dtc` is high.

Top module: `dma_req_qual`

## Requirements
- R1: During and right after reset, `req_pend` and `keep_bus` are low.
- R2: In burst mode (`mode` = 0), `req_pend` and `keep_bus` follow the request pin as an active-low level. Each goes high `SYNC_STAGES` clock edges after `req_n` falls and low `SYNC_STAGES` edges after it rises. Removing the request before any transfer therefore withdraws it.
- R3: In either cycle-steal mode (`mode` = 1 or 2), a falling edge on `req_n` sets `req_pend` `SYNC_STAGES`+1 clock edges after the pin falls. Holding the pin low afterwards creates no further request.
- R4: In the cycle-steal modes, an edge with `last_dtc` high completes the pending operand. `req_pend` is low after that edge if no other request was queued.
- R5: A falling edge that arrives while a request is already pending and the bus is not yet owned is not recognised separately. One `last_dtc` then leaves `req_pend` low.
- R6: In cycle steal without hold (`mode` = 1), `keep_bus` is high in the `last_dtc` cycle only if a new falling edge was seen while the bus was owned, before that cycle. That request then stays pending after the `last_dtc` edge. Otherwise `keep_bus` is low and the bus is released.
- R7: In cycle steal with hold (`mode` = 2), `keep_bus` is high whenever `chan_act` is high.
- R8: With `mixed_en` high, the clock edge that first sees `chan_act` high sets `req_pend` with the pin idle. After that operand's `last_dtc`, `req_pend` stays low until the device makes a request.
- R9: While `chan_act` is low, pin activity is ignored. `req_pend` is low from the second edge after `chan_act` falls. A pin already held low when the channel activates is not an edge in the cycle-steal modes.
- R10: The reserved `mode` value 3 behaves exactly as burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Device request pin, active low, asynchronous |
| mode | input | 2 | 0 burst, 1 cycle steal, 2 cycle steal with hold, 3 reserved (burst) |
| mixed_en | input | 1 | Auto-request the first operand after activation |
| chan_act | input | 1 | Channel started and running |
| bus_owned | input | 1 | Controller currently owns the bus |
| last_dtc | input | 1 | Strobe of the operand's final part |
| req_pend | output | 1 | Operand transfer requested |
| keep_bus | output | 1 | Retain the bus after the current operand |

## Verification
The hardest situation to reach from the ports is the early-request rule in cycle steal without hold. A second falling edge must land in the short window after the bus is owned and before the last strobe. It must also be told apart from a duplicate edge made before the bus was granted. The directed tests build both cases from the same pin pattern: pulse the pin, wait out the synchroniser, pulse it again. The only difference is whether `bus_owned` is raised between the two pulses. Each case then checks `keep_bus` in the strobe cycle and `req_pend` after it.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [1:0] {
    RM_BURST      = 2'd0,
    RM_STEAL      = 2'd1,
    RM_STEAL_HOLD = 2'd2,
    RM_RSVD       = 2'd3
  } rec_mode_e;

  // Edge-recognised modes.
  function automatic logic is_steal(input logic [1:0] m);
    return (m == RM_STEAL) || (m == RM_STEAL_HOLD);
  endfunction

  // Pending flag seen by the sequencer.
  function automatic logic pend_fn(input logic [1:0] m, input logic act,
                                   input logic lvl, input logic dev,
                                   input logic auto_p);
    logic r;
    if (is_steal(m)) r = dev;
    else             r = act & lvl;
    return r | auto_p;
  endfunction

  // Bus retention decision sampled with the last strobe.
  function automatic logic retain_fn(input logic [1:0] m, input logic act,
                                     input logic lvl, input logic queued,
                                     input logic auto_p, input logic dev);
    logic r;
    case (m)
      RM_STEAL:      r = auto_p ? dev : queued;
      RM_STEAL_HOLD: r = 1'b1;
      default:       r = lvl;
    endcase
    return act & r;
  endfunction

endpackage

// File: rtl/rr_sync_edge.sv
module rr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic lvl,
  output logic fall_evt
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= ~pin_n;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], ~pin_n};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];

  assign lvl      = chain[LAST];
  assign fall_evt = chain[LAST] & ~prev;
endmodule

// File: rtl/rr_auto_start.sv
module rr_auto_start (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_act,
  input  logic mixed_en,
  input  logic last_dtc,
  output logic auto_q
);
  logic act_d;
  logic act_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act_d <= 1'b0;
    else        act_d <= chan_act;

  assign act_rise = chan_act & ~act_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    auto_q <= 1'b0;
    else if (!chan_act)            auto_q <= 1'b0;
    else if (act_rise && mixed_en) auto_q <= 1'b1;
    else if (last_dtc)             auto_q <= 1'b0;
endmodule

// File: rtl/rr_steal_track.sv
module rr_steal_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic chan_act,
  input  logic fall_evt,
  input  logic bus_owned,
  input  logic last_dtc,
  input  logic auto_busy,
  output logic dev_pend,
  output logic nxt_q
);
  logic done_dev;

  // A strobe completes the device operand only when no auto operand is in flight.
  assign done_dev = last_dtc & ~auto_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dev_pend <= 1'b0;
      nxt_q    <= 1'b0;
    end else if (!enable || !chan_act) begin
      dev_pend <= 1'b0;
      nxt_q    <= 1'b0;
    end else if (done_dev) begin
      dev_pend <= nxt_q | fall_evt;
      nxt_q    <= 1'b0;
    end else if (fall_evt) begin
      if (!dev_pend)      dev_pend <= 1'b1;
      else if (bus_owned) nxt_q    <= 1'b1;
    end
endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_n,
  input  logic [1:0] mode,
  input  logic       mixed_en,
  input  logic       chan_act,
  input  logic       bus_owned,
  input  logic       last_dtc,
  output logic       req_pend,
  output logic       keep_bus
);
  logic lvl;
  logic fall_evt;
  logic auto_q;
  logic dev_pend;
  logic nxt_q;
  logic steal_en;
  logic dev_edge;

  assign steal_en = rr_pkg::is_steal(mode);
  assign dev_edge = fall_evt & chan_act;

  rr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(req_n), .lvl(lvl), .fall_evt(fall_evt)
  );

  rr_auto_start u_auto (
    .clk(clk), .rst_n(rst_n), .chan_act(chan_act), .mixed_en(mixed_en),
    .last_dtc(last_dtc), .auto_q(auto_q)
  );

  rr_steal_track u_trk (
    .clk(clk), .rst_n(rst_n), .enable(steal_en), .chan_act(chan_act),
    .fall_evt(dev_edge), .bus_owned(bus_owned), .last_dtc(last_dtc),
    .auto_busy(auto_q), .dev_pend(dev_pend), .nxt_q(nxt_q)
  );

  assign req_pend = rr_pkg::pend_fn(mode, chan_act, lvl, dev_pend, auto_q);
  assign keep_bus = rr_pkg::retain_fn(mode, chan_act, lvl, nxt_q, auto_q, dev_pend);
endmodule

// File: rtl/dma_req_qual_chk.sv
module dma_req_qual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       chan_act,
  input logic       bus_owned,
  input logic       last_dtc,
  input logic       req_pend,
  input logic       keep_bus,
  input logic       fall_evt,
  input logic       dev_pend,
  input logic       nxt_q,
  input logic       auto_q
);
  logic steal;
  assign steal = (mode == 2'd1) || (mode == 2'd2);

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    steal && chan_act && fall_evt && !dev_pend && !last_dtc |=> req_pend); // R3

  AST_DTC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    steal && chan_act && last_dtc && !auto_q && !nxt_q && !fall_evt
    && $stable(mode) |=> !req_pend || !$stable(mode)); // R4

  AST_DUP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    steal && chan_act && dev_pend && !bus_owned && fall_evt && !last_dtc
    && !nxt_q |=> !nxt_q); // R5

  AST_EARLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 && chan_act && dev_pend && bus_owned && fall_evt
    && !last_dtc && !auto_q |=> keep_bus || !chan_act || !$stable(mode)); // R6

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    chan_act && mode == 2'd2 |-> keep_bus); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_act && $past(!chan_act) |-> !req_pend && !keep_bus); // R9
endmodule

bind dma_req_qual dma_req_qual_chk u_chk (.*);

// File: tb/sim_dma_req_qual.sv
module sim_dma_req_qual;
  localparam time CLK_PER = 10ns;
  localparam int  SYNC    = 2;
  localparam int  WD_LIM  = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic [1:0] mode = 2'd0;
  logic mixed_en = 1'b0, chan_act = 1'b0, bus_owned = 1'b0, last_dtc = 1'b0;
  logic req_pend, keep_bus;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  dma_req_qual #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .mode(mode), .mixed_en(mixed_en),
    .chan_act(chan_act), .bus_owned(bus_owned), .last_dtc(last_dtc),
    .req_pend(req_pend), .keep_bus(keep_bus)
  );

  // Advance n rising edges, then settle at the falling edge.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] m, input logic mix);
    chan_act = 0; bus_owned = 0; last_dtc = 0; req_n = 1; mixed_en = mix; mode = m;
    rst_n = 0; tick(2); rst_n = 1; tick(SYNC + 1);
  endtask

  task automatic pulse_dtc();
    last_dtc = 1; tick(1); last_dtc = 0;
  endtask

  task automatic req_edge();
    req_n = 1; tick(SYNC + 1); req_n = 0; tick(SYNC + 1);
  endtask

  task automatic t_reset();
    rst_n = 0; tick(1);
    chk("R1", req_pend, 0, "pend in reset");
    chk("R1", keep_bus, 0, "keep in reset");
    rst_n = 1; tick(1);
    chk("R1", req_pend, 0, "pend after reset");
  endtask

  task automatic t_burst(input logic [1:0] m, input string rq);
    restart(m, 0); chan_act = 1; tick(1);
    req_n = 0; tick(SYNC - 1);
    chk(rq, req_pend, 0, "burst pend before sync");
    tick(1);
    chk(rq, req_pend, 1, "burst pend level");
    chk(rq, keep_bus, 1, "burst keep level");
    req_n = 1; tick(SYNC);
    chk(rq, req_pend, 0, "burst withdrawn");
  endtask

  task automatic t_steal_edge();
    restart(2'd1, 0); chan_act = 1; tick(1);
    req_n = 0; tick(SYNC);
    chk("R3", req_pend, 0, "edge not yet registered");
    tick(1);
    chk("R3", req_pend, 1, "edge sets pend");
    bus_owned = 1; tick(1); pulse_dtc();
    chk("R4", req_pend, 0, "pend cleared by last strobe");
    tick(SYNC + 2);
    chk("R3", req_pend, 0, "held low pin gives no new request");
  endtask

  task automatic t_dup();
    restart(2'd1, 0); chan_act = 1; tick(1);
    req_edge();
    chk("R5", req_pend, 1, "first edge pending");
    req_edge();
    bus_owned = 1; tick(1);
    last_dtc = 1; #1;
    chk("R6", keep_bus, 0, "no early request releases bus");
    tick(1); last_dtc = 0;
    chk("R5", req_pend, 0, "duplicate edge dropped");
  endtask

  task automatic t_early();
    restart(2'd1, 0); chan_act = 1; tick(1);
    req_edge();
    bus_owned = 1; tick(1);
    req_edge();
    last_dtc = 1; #1;
    chk("R6", keep_bus, 1, "early edge keeps bus");
    tick(1); last_dtc = 0;
    chk("R6", req_pend, 1, "early edge still pending");
    last_dtc = 1; #1;
    chk("R6", keep_bus, 0, "released after queued op");
    tick(1); last_dtc = 0;
    chk("R4", req_pend, 0, "queue drained");
  endtask

  task automatic t_hold();
    restart(2'd2, 0); tick(1);
    chk("R7", keep_bus, 0, "hold inactive channel");
    chan_act = 1; tick(1);
    chk("R7", keep_bus, 1, "hold keeps bus idle");
    req_edge(); pulse_dtc();
    chk("R7", keep_bus, 1, "hold keeps bus after op");
    chk("R4", req_pend, 0, "hold pend cleared");
  endtask

  task automatic t_mixed();
    restart(2'd1, 1);
    chan_act = 1; tick(1);
    chk("R8", req_pend, 1, "auto first request");
    bus_owned = 1; pulse_dtc();
    chk("R8", req_pend, 0, "waits for device");
    tick(3);
    chk("R8", req_pend, 0, "no further auto request");
    req_edge();
    chk("R8", req_pend, 1, "device request after auto");
  endtask

  task automatic t_inactive();
    restart(2'd1, 0);
    req_n = 0; tick(SYNC + 2);
    chk("R9", req_pend, 0, "edge ignored while inactive");
    chan_act = 1; tick(SYNC + 1);
    chk("R9", req_pend, 0, "low pin at activation is no edge");
    req_edge();
    chk("R9", req_pend, 1, "edge after activation");
    chan_act = 0; tick(1);
    chk("R9", req_pend, 0, "deactivation clears pend");
  endtask

  initial begin : watchdog
    repeat (WD_LIM) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    tick(2);
    t_reset();
    t_burst(2'd0, "R2");
    t_burst(2'd3, "R10");
    t_steal_edge();
    t_dup();
    t_early();
    t_hold();
    t_mixed();
    t_inactive();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule